// File: doc/BRIEF.md
# Compare/Capture Timer Channel with PWM

This block is a single timer channel built around a counter that advances on an external count-enable tick. Two general registers, A and B, sit beside the counter. Each one can act as an output-compare register that changes a pin when the counter reaches it. Each one can instead act as an input-capture register that latches the counter on a chosen edge of an external pin. A PWM mode uses A and B together to produce a single waveform. A or B can set the period through counter clearing, and the other sets the duty cycle.

Several such channels can be tied together. When the sync bit is set, a software write to the counter is also sent out as a preset strobe with its value. A clear caused by A or B is sent out as a clear strobe. The channel accepts preset and clear strobes from its siblings. Software uses a small write/read register port with one cycle of read latency. Sticky status flags record compare/capture events and counter overflow.

Top module: `timer_chan`

## Requirements
- R1: After reset, every register reads zero, and `out_a`, `out_b`, `flags`, `sync_preset_out` and `sync_clear_out` are 0.
- R2: The counter adds one only on a clock edge where `tick` is high, and otherwise holds. With clear select 00 it wraps from 0xFFFF to 0x0000, and that wrap sets status bit 2 (overflow).
- R3: CTRL bits [3:2] select the clear source: 01 clears on an A event, 10 on a B event, and 11 on `sync_clear_in` while the sync bit is set. An event is a match or a capture. A clear wins over the increment, so the counter becomes 0 on that edge. With clear-on-A and a compare value N, the count after T ticks from 0 is T mod (N+1).
- R4: A compare match is a tick while the counter equals the register. In compare mode (IOCTL mode bit 0 for A and bit 4 for B), the action field (bits [2:1] for A, [6:5] for B) decides the pin on a match: 00 holds it, 01 drives 0, 10 drives 1 and 11 toggles it. The pin is registered.
- R5: In capture mode (mode bit 1), the same field selects the edge: 01 rising, 10 falling, 11 both, 00 none. The pin passes through two synchronizer flops, and on the selected edge the counter value is copied into the register.
- R6: With CTRL bit 0 (PWM) set, `out_a` goes high on an A match and low on a B match. If both match in the same cycle, `out_a` is unchanged. `out_b` holds.
- R7: In PWM mode both registers behave as compare registers whatever their mode bits are, and capture edges leave them unchanged.
- R8: Status bits are 0 for A event, 1 for B event and 2 for overflow, and they are sticky. Writing STAT clears the bits written as 0 and leaves the bits written as 1. A new event in the same cycle wins over the clear.
- R9: With CTRL bit 1 (sync) set, a COUNT write produces a one-cycle `sync_preset_out` pulse on the next cycle, with the written value on `sync_value_out`. A `sync_preset_in` pulse loads `sync_value_in` into the counter. With the sync bit clear, `sync_preset_in` is ignored.
- R10: With the sync bit set and clear source 01 or 10, a clear caused by this channel raises `sync_clear_out` for the cycle after that clear.
- R11: The register map is 0 CTRL, 1 IOCTL, 2 STAT, 3 COUNT, 4 A, 5 B. A read returns the addressed value on `rdata` one cycle after `addr` is presented. CTRL and IOCTL read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| tick | input | 1 | Count enable from external prescaler |
| cap_a | input | 1 | Capture pin for register A |
| cap_b | input | 1 | Capture pin for register B |
| out_a | output | 1 | Compare / PWM output A |
| out_b | output | 1 | Compare output B |
| sync_preset_in | input | 1 | Preset strobe from sibling channels |
| sync_value_in | input | 16 | Preset value from sibling channels |
| sync_clear_in | input | 1 | Clear strobe from sibling channels |
| sync_preset_out | output | 1 | Preset strobe to sibling channels |
| sync_value_out | output | 16 | Preset value to sibling channels |
| sync_clear_out | output | 1 | Clear strobe to sibling channels |
| flags | output | 3 | Status flags: A event, B event, overflow |

## Verification
In PWM mode, compare match A and compare match B can fire on the same tick. The bench provokes this by setting both registers to the same value with clear-on-A. It then follows `out_a` on every tick against an arithmetic model in which a coincident pair leaves the level unchanged. The same edge can also carry a clear and an increment. Sweeps of the period register judge this by checking that the count equals the tick count modulo the period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_IOCTL = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_COUNT = 3'd3;
  localparam logic [2:0] A_GRA   = 3'd4;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_A    = 2'b01,
    CLR_B    = 2'b10,
    CLR_SYNC = 2'b11
  } clr_e;

  // sel: compare action or capture edge; cap_mode = 1 selects capture
  typedef struct packed {
    logic [1:0] sel;
    logic       cap_mode;
  } gr_cfg_t;
endpackage

// File: rtl/tmr_cap_sync.sv
module tmr_cap_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       hit
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sq;
  logic              prev;
  logic              rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq   <= '0;
      prev <= 1'b0;
    end else begin
      sq   <= {sq[STAGES-2:0], pin};
      prev <= sq[LAST];
    end
  end

  assign rise = sq[LAST] & ~prev;
  assign fall = ~sq[LAST] & prev;
  assign hit  = (edge_sel[0] & rise) | (edge_sel[1] & fall);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  assign ovf = tick && !clr && !load && (cnt == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && !load) |=> (cnt == $past(cnt) + 1'b1));
  // R2
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr && !load) |=> $stable(cnt));
  // R3
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !load) |=> (cnt == '0));
endmodule

// File: rtl/tmr_genreg.sv
module tmr_genreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         cap_mode,
  input  logic         pwm_en,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         cap_hit,
  output logic [W-1:0] gr,
  output logic         match,
  output logic         capt
);
  logic cap_on;

  assign cap_on = cap_mode && !pwm_en;
  assign match  = tick && !cap_on && (cnt == gr);
  assign capt   = cap_on && cap_hit;

  always_ff @(posedge clk) begin
    if (rst)       gr <= '0;
    else if (wr)   gr <= wdata;
    else if (capt) gr <= cnt;
  end

  // R7
  gr_pwm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_en && !wr) |=> $stable(gr));
endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             tick,
  input  logic             cap_a,
  input  logic             cap_b,
  output logic             out_a,
  output logic             out_b,
  input  logic             sync_preset_in,
  input  logic [CNT_W-1:0] sync_value_in,
  input  logic             sync_clear_in,
  output logic             sync_preset_out,
  output logic [CNT_W-1:0] sync_value_out,
  output logic             sync_clear_out,
  output logic [2:0]       flags
);
  localparam int NGR = 2;

  logic             pwm_en, sync_en;
  clr_e             clr_sel;
  gr_cfg_t          cfg [NGR];
  logic [NGR-1:0]   wr_gr, match, capt, ev, cap_hit, pin_in;
  logic [CNT_W-1:0] gr [NGR];
  logic [CNT_W-1:0] cnt, load_val;
  logic             wr_ctrl, wr_io, wr_stat, wr_cnt;
  logic             clr, own_clr, load, ovf_pulse;
  logic [2:0]       flags_q, flag_set;
  logic [NGR-1:0]   out_q;

  assign pin_in  = {cap_b, cap_a};
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_io   = wr_en && (addr == A_IOCTL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_cnt  = wr_en && (addr == A_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_en  <= 1'b0;
      sync_en <= 1'b0;
      clr_sel <= CLR_NONE;
      for (int i = 0; i < NGR; i++) cfg[i] <= '0;
    end else begin
      if (wr_ctrl) begin
        pwm_en  <= wdata[0];
        sync_en <= wdata[1];
        clr_sel <= clr_e'(wdata[3:2]);
      end
      if (wr_io)
        for (int i = 0; i < NGR; i++) cfg[i] <= gr_cfg_t'(wdata[4*i +: 3]);
    end
  end

  for (genvar g = 0; g < NGR; g++) begin : g_gr
    localparam logic [2:0] GADDR = A_GRA + 3'(g);
    assign wr_gr[g] = wr_en && (addr == GADDR);

    tmr_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .pin      (pin_in[g]),
      .edge_sel (cfg[g].sel),
      .hit      (cap_hit[g])
    );

    tmr_genreg #(.W(CNT_W)) u_gr (
      .clk      (clk),
      .rst      (rst),
      .wr       (wr_gr[g]),
      .wdata    (wdata),
      .cap_mode (cfg[g].cap_mode),
      .pwm_en   (pwm_en),
      .tick     (tick),
      .cnt      (cnt),
      .cap_hit  (cap_hit[g]),
      .gr       (gr[g]),
      .match    (match[g]),
      .capt     (capt[g])
    );
  end

  assign ev       = match | capt;
  assign own_clr  = ((clr_sel == CLR_A) && ev[0]) || ((clr_sel == CLR_B) && ev[1]);
  assign clr      = own_clr || ((clr_sel == CLR_SYNC) && sync_en && sync_clear_in);
  assign load     = wr_cnt || (sync_en && sync_preset_in);
  assign load_val = wr_cnt ? wdata : sync_value_in;

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .clr      (clr),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .ovf      (ovf_pulse)
  );

  // status flags: set wins over software clear
  assign flag_set = {ovf_pulse, ev};

  always_ff @(posedge clk) begin
    if (rst)          flags_q <= '0;
    else if (wr_stat) flags_q <= (flags_q & wdata[2:0]) | flag_set;
    else              flags_q <= flags_q | flag_set;
  end

  // pin outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (pwm_en) begin
      if (match[0] && !match[1])      out_q[0] <= 1'b1;
      else if (match[1] && !match[0]) out_q[0] <= 1'b0;
    end else begin
      for (int i = 0; i < NGR; i++) begin
        if (match[i]) begin
          case (act_e'(cfg[i].sel))
            ACT_LOW:    out_q[i] <= 1'b0;
            ACT_HIGH:   out_q[i] <= 1'b1;
            ACT_TOGGLE: out_q[i] <= ~out_q[i];
            default:    out_q[i] <= out_q[i];
          endcase
        end
      end
    end
  end

  // sibling strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_preset_out <= 1'b0;
      sync_value_out  <= '0;
      sync_clear_out  <= 1'b0;
    end else begin
      sync_preset_out <= wr_cnt && sync_en;
      if (wr_cnt) sync_value_out <= wdata;
      sync_clear_out  <= own_clr && sync_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        3'd0:    rdata <= {{(CNT_W-4){1'b0}}, clr_sel, sync_en, pwm_en};
        3'd1:    rdata <= {{(CNT_W-7){1'b0}}, cfg[1], 1'b0, cfg[0]};
        3'd2:    rdata <= {{(CNT_W-3){1'b0}}, flags_q};
        3'd3:    rdata <= cnt;
        3'd4:    rdata <= gr[0];
        3'd5:    rdata <= gr[1];
        default: rdata <= '0;
      endcase
    end
  end

  assign out_a = out_q[0];
  assign out_b = out_q[1];
  assign flags = flags_q;

  // R6
  pwm_tie_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_en && match[0] && match[1]) |=> $stable(out_q[0]));
  // R6
  pwm_b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_en |=> $stable(out_q[1]));
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> flags_q[2]);
  // R10
  sync_clr_out_chk: assert property (@(posedge clk) disable iff (rst)
    sync_clear_out |-> sync_en && $past(sync_en));
endmodule

// File: tb/timer_chan_bench.sv
module timer_chan_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tick = 1'b0, cap_a = 1'b0, cap_b = 1'b0;
  logic        out_a, out_b;
  logic        sync_preset_in = 1'b0, sync_clear_in = 1'b0;
  logic [15:0] sync_value_in = '0;
  logic        sync_preset_out, sync_clear_out;
  logic [15:0] sync_value_out;
  logic [2:0]  flags;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  timer_chan u_timer_chan (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .cap_a(cap_a), .cap_b(cap_b),
    .out_a(out_a), .out_b(out_b), .sync_preset_in(sync_preset_in),
    .sync_value_in(sync_value_in), .sync_clear_in(sync_clear_in),
    .sync_preset_out(sync_preset_out), .sync_value_out(sync_value_out),
    .sync_clear_out(sync_clear_out), .flags(flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v, prev;
    logic        o;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 pins", {out_a, out_b, flags, sync_preset_out, sync_clear_out}, 0);

    // R2 wrap and overflow
    wr(3'd3, 16'hFFFD);
    ticks(4);
    rd(3'd3, v);
    chk("R2 wrap count", v, 16'h0001);
    rd(3'd2, v);
    chk("R2 overflow flag", v, 16'h0007);
    idle(3);
    rd(3'd3, v);
    chk("R2 hold without tick", v, 16'h0001);

    // R8 flag write semantics
    wr(3'd2, 16'h0007);
    rd(3'd2, v);
    chk("R8 write ones keeps", v, 16'h0007);
    wr(3'd2, 16'h0003);
    rd(3'd2, v);
    chk("R8 write zero clears bit2", v, 16'h0003);
    wr(3'd2, 16'h0000);
    chk("R8 flags port clear", flags, 0);

    // R4 compare action sweep on A
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'd3);
    o = out_a;
    for (int s = 0; s < 6; s++) begin
      int act;
      act = (s * 3 + 2) % 4;
      wr(3'd1, 16'(act << 1));
      wr(3'd3, 16'd0);
      ticks(5);
      case (act)
        1: o = 1'b0;
        2: o = 1'b1;
        3: o = ~o;
        default: o = o;
      endcase
      chk("R4 compare action", out_a, o);
    end

    // R3 clear on A, period sweep
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0004);
    for (int n = 2; n <= 6; n++) begin
      wr(3'd4, 16'(n));
      wr(3'd3, 16'd0);
      ticks(13);
      rd(3'd3, v);
      chk("R3 clear on A", v, 16'(13 % (n + 1)));
    end
    // R3 clear on B
    wr(3'd4, 16'hFFF0);
    wr(3'd0, 16'h0008);
    for (int n = 3; n <= 5; n++) begin
      wr(3'd5, 16'(n));
      wr(3'd3, 16'd0);
      ticks(17);
      rd(3'd3, v);
      chk("R3 clear on B", v, 16'(17 % (n + 1)));
    end

    // R6 PWM waveform sweep, including coincident matches
    for (int p = 3; p <= 6; p++) begin
      for (int d = 1; d <= 7; d += 2) begin
        int c;
        wr(3'd0, 16'h0005);
        wr(3'd1, 16'h0000);
        wr(3'd4, 16'(p));
        wr(3'd5, 16'(d == 7 ? p : d));
        wr(3'd3, 16'd0);
        c = 0;
        o = out_a;
        for (int k = 0; k < 3 * (p + 1) + 2; k++) begin
          logic ma, mb;
          tick = 1'b1;
          @(negedge clk);
          ma = (c == p);
          mb = (c == (d == 7 ? p : d));
          if (ma && !mb) o = 1'b1;
          else if (mb && !ma) o = 1'b0;
          c = ma ? 0 : c + 1;
          chk("R6 pwm out_a", out_a, o);
        end
        tick = 1'b0;
      end
    end

    // R5 capture edge sweep on A
    wr(3'd0, 16'h0000);
    for (int e = 0; e < 4; e++) begin
      logic [15:0] ex;
      wr(3'd1, 16'((e << 1) | 1));
      wr(3'd4, 16'h1234);
      wr(3'd3, 16'(16'h0100 + e));
      cap_a = 1'b1;
      idle(5);
      rd(3'd4, v);
      ex = (e & 1) ? 16'(16'h0100 + e) : 16'h1234;
      chk("R5 rising capture", v, ex);
      wr(3'd3, 16'(16'h0200 + e));
      cap_a = 1'b0;
      idle(5);
      rd(3'd4, v);
      ex = (e & 2) ? 16'(16'h0200 + e) : ex;
      chk("R5 falling capture", v, ex);
    end

    // R7 PWM ignores capture
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h0007);
    wr(3'd4, 16'h0077);
    wr(3'd3, 16'h0500);
    cap_a = 1'b1; idle(5);
    cap_a = 1'b0; idle(5);
    rd(3'd4, v);
    chk("R7 no capture in pwm", v, 16'h0077);

    // R9 sync preset out / in
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0002);
    wr(3'd3, 16'h0042);
    chk("R9 preset out pulse", sync_preset_out, 1);
    chk("R9 preset out value", sync_value_out, 16'h0042);
    @(negedge clk);
    chk("R9 preset out ends", sync_preset_out, 0);
    sync_preset_in = 1'b1; sync_value_in = 16'h0ABC;
    @(negedge clk);
    sync_preset_in = 1'b0;
    rd(3'd3, v);
    chk("R9 preset in loads", v, 16'h0ABC);
    wr(3'd0, 16'h0000);
    sync_preset_in = 1'b1; sync_value_in = 16'h0DEF;
    @(negedge clk);
    sync_preset_in = 1'b0;
    rd(3'd3, v);
    chk("R9 preset in ignored", v, 16'h0ABC);

    // R3 sync clear in
    wr(3'd0, 16'h000E);
    wr(3'd3, 16'h0030);
    sync_clear_in = 1'b1;
    @(negedge clk);
    sync_clear_in = 1'b0;
    rd(3'd3, v);
    chk("R3 sync clear in", v, 16'h0000);

    // R10 sync clear out
    wr(3'd0, 16'h0006);
    wr(3'd4, 16'd2);
    wr(3'd3, 16'd0);
    prev = 16'(sync_clear_out);
    chk("R10 idle clear out", prev, 0);
    ticks(3);
    chk("R10 clear out pulse", sync_clear_out, 1);
    @(negedge clk);
    chk("R10 clear out ends", sync_clear_out, 0);

    // R11 readback
    wr(3'd0, 16'h000B);
    rd(3'd0, v);
    chk("R11 ctrl readback", v, 16'h000B);
    wr(3'd1, 16'h0075);
    rd(3'd1, v);
    chk("R11 ioctl readback", v, 16'h0075);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule